// File: doc/BRIEF.md
# Bank-Aware DRAM Request Arbiter

This block picks the next request to serve from a small queue of pending DRAM requests. Entry 0 is the oldest and the highest index is the newest. Each entry reports whether it is valid, its rank, its bank group and whether its row is already open. It also reports a ready time. For a closed row this is the cycle at which its bank may be activated. For an open row it is the cycle at which a column command may go to it.

The arbiter also receives the current cycle and the cycle of the previous column burst, together with that burst's rank and bank group. It is told whether the command direction is switching between read and write. The timing values arrive as inputs. From these it works out whether each request's burst can follow the previous burst with no idle gap on the data bus.

Requests fall into three priority classes, and the oldest request in the best non-empty class is chosen. When no request falls into any class, the request whose bank becomes ready soonest is chosen. The decision is combinational over the whole queue and is registered into a one-hot grant, a found flag and a no-gap flag. The block does not issue commands, track row state or carry data.

Top module: `dram_req_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `grant`, `found` and `seamless` are all 0.
- R2: Outputs are registered. The result for the inputs present before a rising clock edge appears just after that edge, so a new decision can be made every cycle.
- R3: An entry with its `req_valid` bit at 0 is never granted. When no entry is valid, `found` is 0 and `grant` is all zeros. Otherwise `found` is 1 and `grant` has exactly one bit set: bit i selects entry i.
- R4: Any valid entry with an open row whose burst can go with no gap wins over all other entries. Among such entries the lowest index (the oldest) wins.
- R5: When R4 picks nothing, a valid closed-row entry whose activate plus `t_rcd` still lets its burst go with no gap wins. The lowest index wins among such entries.
- R6: When R4 and R5 pick nothing, a valid open-row entry whose burst would leave a gap wins. The lowest index wins, regardless of ready time.
- R7: When no entry falls under R4 to R6, the valid entry with the smallest clamped ready time wins. Ties go to the lowest index.
- R8: An entry's no-gap deadline is `prev_col` plus a spacing term. The term is `t_ccd_l` when the entry has the same rank and bank group as the previous burst, `t_ccd_s` for the same rank and a different bank group, and `t_ccd_s + t_cs` for a different rank.
- R9: When `dir_switch` is 1, `t_turn` is added to every entry's no-gap deadline.
- R10: A ready time earlier than `now` counts as `now`. An entry's earliest column time is its clamped ready time, plus `t_rcd` if its row is closed. The burst has no gap when this time is at or below the deadline.
- R11: `seamless` is 1 exactly when the grant came from R4 or R5, and 0 for grants from R6 or R7 and when nothing is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Entry valid bits, bit 0 is the oldest entry |
| req_open | input | N | Entry row-open flags |
| req_rank | input | N*RANK_W | Entry ranks, packed with entry 0 in the low bits |
| req_bg | input | N*BG_W | Entry bank groups, packed with entry 0 in the low bits |
| req_ready | input | N*TIME_W | Entry ready times (activate time if closed, column time if open) |
| now | input | TIME_W | Current cycle |
| prev_col | input | TIME_W | Cycle of the previous column burst |
| prev_rank | input | RANK_W | Rank of the previous burst |
| prev_bg | input | BG_W | Bank group of the previous burst |
| dir_switch | input | 1 | Read/write direction change pending |
| t_ccd_s | input | TCK_W | Column spacing, different bank group |
| t_ccd_l | input | TCK_W | Column spacing, same bank group |
| t_cs | input | TCK_W | Extra spacing on a rank change |
| t_rcd | input | TCK_W | Activate-to-column delay |
| t_turn | input | TCK_W | Extra column delay on a direction change |
| grant | output | N | One-hot chosen entry |
| found | output | 1 | A valid entry was chosen |
| seamless | output | 1 | Chosen burst follows the previous one with no gap |

## Verification
The hardest situations to reach are those where a spacing or clamp rule alone decides the class of an entry. Examples are an open-row entry that has no gap under `t_ccd_l` but would have a gap under `t_ccd_s`, and an old ready time whose clamping to `now` turns a no-gap burst into a gap. The stimulus sets each ready time exactly on, or one cycle past, the deadline computed from the spacing rule under test. In the same vector it places a competing entry in another class, so a wrong rule changes which bit is granted. Fallback ties and ordering within a class are reached by giving several entries equal clamped ready times, or by putting the oldest member of a class behind a newer entry that becomes ready sooner.

// File: rtl/dra_pkg.sv
package dra_pkg;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_HIT    = 2'd1,
    CLS_HIDDEN = 2'd2,
    CLS_BUBBLE = 2'd3
  } cls_e;

endpackage

// File: rtl/dra_entry_eval.sv
module dra_entry_eval #(
  parameter int RANK_W = 2,
  parameter int BG_W   = 2,
  parameter int TIME_W = 16,
  parameter int TCK_W  = 6
) (
  input  logic              valid,
  input  logic              row_open,
  input  logic [RANK_W-1:0] rank,
  input  logic [BG_W-1:0]   bg,
  input  logic [TIME_W-1:0] ready,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] prev_col,
  input  logic [RANK_W-1:0] prev_rank,
  input  logic [BG_W-1:0]   prev_bg,
  input  logic              dir_switch,
  input  logic [TCK_W-1:0]  t_ccd_s,
  input  logic [TCK_W-1:0]  t_ccd_l,
  input  logic [TCK_W-1:0]  t_cs,
  input  logic [TCK_W-1:0]  t_rcd,
  input  logic [TCK_W-1:0]  t_turn,
  output logic [TIME_W-1:0] prep_at,
  output logic              hit,
  output logic              hidden,
  output logic              bubble
);
  localparam int EXT_W = TIME_W + 2;

  logic [EXT_W-1:0] spacing;
  logic [EXT_W-1:0] turn_add;
  logic [EXT_W-1:0] seam_at;
  logic [EXT_W-1:0] col_at;
  logic             no_gap;

  // R10: ready times in the past are treated as now
  always_comb begin
    prep_at = (ready > now) ? ready : now;
  end

  // R8 / R9: deadline for a gap-free burst
  always_comb begin
    if (rank != prev_rank)
      spacing = EXT_W'(t_ccd_s) + EXT_W'(t_cs);
    else if (bg == prev_bg)
      spacing = EXT_W'(t_ccd_l);
    else
      spacing = EXT_W'(t_ccd_s);
    turn_add = dir_switch ? EXT_W'(t_turn) : '0;
    seam_at  = EXT_W'(prev_col) + spacing + turn_add;
  end

  always_comb begin
    col_at = EXT_W'(prep_at) + (row_open ? '0 : EXT_W'(t_rcd));
    no_gap = (col_at <= seam_at);
    hit    = valid &  row_open &  no_gap;
    hidden = valid & ~row_open &  no_gap;
    bubble = valid &  row_open & ~no_gap;
  end

endmodule

// File: rtl/dra_oldest_pick.sv
module dra_oldest_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  // lowest set bit = oldest entry
  always_comb begin
    gnt = req & (~req + N'(1));
    any = |req;
  end

endmodule

// File: rtl/dra_min_pick.sv
module dra_min_pick #(
  parameter int N      = 8,
  parameter int TIME_W = 16
) (
  input  logic [N-1:0]        valid,
  input  logic [N*TIME_W-1:0] times,
  output logic [N-1:0]        gnt
);
  logic [TIME_W-1:0] best_t;
  logic              have;

  // strict less-than keeps the lowest index on ties (R7)
  always_comb begin
    gnt    = '0;
    best_t = '0;
    have   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (!have || times[i*TIME_W +: TIME_W] < best_t)) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        best_t = times[i*TIME_W +: TIME_W];
        have   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dram_req_arbiter.sv
module dram_req_arbiter #(
  parameter int N      = 8,
  parameter int RANK_W = 2,
  parameter int BG_W   = 2,
  parameter int TIME_W = 16,
  parameter int TCK_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        req_valid,
  input  logic [N-1:0]        req_open,
  input  logic [N*RANK_W-1:0] req_rank,
  input  logic [N*BG_W-1:0]   req_bg,
  input  logic [N*TIME_W-1:0] req_ready,
  input  logic [TIME_W-1:0]   now,
  input  logic [TIME_W-1:0]   prev_col,
  input  logic [RANK_W-1:0]   prev_rank,
  input  logic [BG_W-1:0]     prev_bg,
  input  logic                dir_switch,
  input  logic [TCK_W-1:0]    t_ccd_s,
  input  logic [TCK_W-1:0]    t_ccd_l,
  input  logic [TCK_W-1:0]    t_cs,
  input  logic [TCK_W-1:0]    t_rcd,
  input  logic [TCK_W-1:0]    t_turn,
  output logic [N-1:0]        grant,
  output logic                found,
  output logic                seamless
);
  import dra_pkg::*;

  logic [N-1:0]        hit, hidden, bubble;
  logic [N*TIME_W-1:0] prep_flat;
  logic [N-1:0]        g_hit, g_hidden, g_bubble, g_min;
  logic                a_hit, a_hidden, a_bubble;
  logic [N-1:0]        grant_d;
  cls_e                cls_d;

  logic [N-1:0]        grant_q;
  logic                found_q;
  logic                seamless_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    dra_entry_eval #(
      .RANK_W(RANK_W), .BG_W(BG_W), .TIME_W(TIME_W), .TCK_W(TCK_W)
    ) u_eval (
      .valid     (req_valid[i]),
      .row_open  (req_open[i]),
      .rank      (req_rank[i*RANK_W +: RANK_W]),
      .bg        (req_bg[i*BG_W +: BG_W]),
      .ready     (req_ready[i*TIME_W +: TIME_W]),
      .now       (now),
      .prev_col  (prev_col),
      .prev_rank (prev_rank),
      .prev_bg   (prev_bg),
      .dir_switch(dir_switch),
      .t_ccd_s   (t_ccd_s),
      .t_ccd_l   (t_ccd_l),
      .t_cs      (t_cs),
      .t_rcd     (t_rcd),
      .t_turn    (t_turn),
      .prep_at   (prep_flat[i*TIME_W +: TIME_W]),
      .hit       (hit[i]),
      .hidden    (hidden[i]),
      .bubble    (bubble[i])
    );
  end

  dra_oldest_pick #(.N(N)) u_pick_hit    (.req(hit),    .gnt(g_hit),    .any(a_hit));
  dra_oldest_pick #(.N(N)) u_pick_hidden (.req(hidden), .gnt(g_hidden), .any(a_hidden));
  dra_oldest_pick #(.N(N)) u_pick_bubble (.req(bubble), .gnt(g_bubble), .any(a_bubble));

  dra_min_pick #(.N(N), .TIME_W(TIME_W)) u_pick_min (
    .valid(req_valid),
    .times(prep_flat),
    .gnt  (g_min)
  );

  // class priority: hit, hidden activate, bubble, then soonest ready
  always_comb begin
    if (a_hit) begin
      cls_d   = CLS_HIT;
      grant_d = g_hit;
    end else if (a_hidden) begin
      cls_d   = CLS_HIDDEN;
      grant_d = g_hidden;
    end else if (a_bubble) begin
      cls_d   = CLS_BUBBLE;
      grant_d = g_bubble;
    end else begin
      cls_d   = CLS_NONE;
      grant_d = g_min;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q    <= '0;
      found_q    <= 1'b0;
      seamless_q <= 1'b0;
    end else begin
      grant_q    <= grant_d;
      found_q    <= |req_valid;
      seamless_q <= (cls_d == CLS_HIT) || (cls_d == CLS_HIDDEN);
    end
  end

  assign grant    = grant_q;
  assign found    = found_q;
  assign seamless = seamless_q;

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    found_q |-> $onehot(grant_q));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !found_q |-> ($countones(grant_q) == 0));

  p_no_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !(|req_valid) |=> !found_q);

  p_grant_valid_r3: assert property (@(posedge clk) disable iff (rst)
    found_q |-> ((grant_q & ~$past(req_valid)) == '0));

  p_hit_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> (seamless_q && ((grant_q & $past(hit)) != '0)));

  p_seam_found_r11: assert property (@(posedge clk) disable iff (rst)
    seamless_q |-> found_q);

endmodule

// File: tb/sim_dram_req_arbiter.sv
`timescale 1ns/1ps
module sim_dram_req_arbiter;
  localparam int N = 8, RANK_W = 2, BG_W = 2, TIME_W = 16, TCK_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]        req_valid, req_open;
  logic [N*RANK_W-1:0] req_rank;
  logic [N*BG_W-1:0]   req_bg;
  logic [N*TIME_W-1:0] req_ready;
  logic [TIME_W-1:0]   now, prev_col;
  logic [RANK_W-1:0]   prev_rank;
  logic [BG_W-1:0]     prev_bg;
  logic                dir_switch;
  logic [TCK_W-1:0]    t_ccd_s, t_ccd_l, t_cs, t_rcd, t_turn;
  logic [N-1:0]        grant;
  logic                found, seamless;

  dram_req_arbiter #(.N(N), .RANK_W(RANK_W), .BG_W(BG_W), .TIME_W(TIME_W), .TCK_W(TCK_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_open(req_open),
    .req_rank(req_rank), .req_bg(req_bg), .req_ready(req_ready),
    .now(now), .prev_col(prev_col), .prev_rank(prev_rank), .prev_bg(prev_bg),
    .dir_switch(dir_switch), .t_ccd_s(t_ccd_s), .t_ccd_l(t_ccd_l),
    .t_cs(t_cs), .t_rcd(t_rcd), .t_turn(t_turn),
    .grant(grant), .found(found), .seamless(seamless)
  );

  typedef struct {
    logic         f;
    logic [N-1:0] g;
    logic         s;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  task automatic clr();
    req_valid = '0; req_open = '0; req_rank = '0; req_bg = '0; req_ready = '0;
  endtask

  task automatic ent(input int i, input bit o, input int r, input int g, input int t);
    req_valid[i] = 1'b1;
    req_open[i]  = o;
    req_rank[i*RANK_W +: RANK_W] = RANK_W'(r);
    req_bg[i*BG_W +: BG_W]       = BG_W'(g);
    req_ready[i*TIME_W +: TIME_W] = TIME_W'(t);
  endtask

  task automatic base();
    now = 16'd100; prev_col = 16'd100; prev_rank = '0; prev_bg = '0; dir_switch = 1'b0;
    t_ccd_s = 6'd4; t_ccd_l = 6'd6; t_cs = 6'd2; t_rcd = 6'd10; t_turn = 6'd5;
    clr();
  endtask

  // driver: inputs applied at negedge, expected item queued for the next posedge
  task automatic drive(input bit f, input int idx, input bit s, input string tag);
    exp_t e;
    e.f = f; e.g = f ? (N'(1) << idx) : '0; e.s = s; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (found !== e.f || grant !== e.g || seamless !== e.s) begin
          n_fail++;
          $display("FAIL %s: got found=%0b grant=%b seamless=%0b, expected found=%0b grant=%b seamless=%0b",
                   e.tag, found, grant, seamless, e.f, e.g, e.s);
        end
      end
    end
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    n_run++;
    if (grant !== '0 || found !== 1'b0 || seamless !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got found=%0b grant=%b seamless=%0b, expected 0 0 0", found, grant, seamless);
    end
    rst = 1'b0;
    n_run++;
    #5;
    if (grant !== '0 || found !== 1'b0 || seamless !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after release: got found=%0b grant=%b seamless=%0b, expected 0 0 0", found, grant, seamless);
    end
    @(negedge clk);

    // deadlines with defaults: same rank+bg 106, same rank other bg 104, other rank 106
    base(); drive(1'b0, 0, 1'b0, "R3 empty queue");

    base(); ent(0, 1, 0, 0, 100); req_valid[0] = 1'b0; ent(4, 1, 0, 0, 110);
    drive(1'b1, 4, 1'b0, "R3 invalid entry ignored");

    base(); ent(0, 1, 0, 0, 110); ent(2, 1, 0, 1, 103); ent(5, 1, 0, 1, 100);
    drive(1'b1, 2, 1'b1, "R4 oldest open no-gap");
    // back-to-back different vector
    base(); ent(1, 0, 0, 0, 150); ent(6, 1, 0, 0, 106);
    drive(1'b1, 6, 1'b1, "R2 next cycle decision");

    base(); prev_col = 16'd120; ent(1, 1, 0, 0, 130); ent(3, 0, 0, 1, 112);
    drive(1'b1, 3, 1'b1, "R5 hidden activate beats bubble");

    base(); ent(0, 1, 0, 1, 105); ent(1, 1, 0, 0, 106);
    drive(1'b1, 1, 1'b1, "R8 same group uses long spacing");

    base(); ent(0, 1, 1, 1, 106); ent(1, 1, 1, 1, 107);
    drive(1'b1, 0, 1'b1, "R8 rank change at deadline");

    base(); ent(0, 1, 1, 1, 107);
    drive(1'b1, 0, 1'b0, "R8 rank change one past deadline");

    base(); ent(1, 0, 0, 0, 200); ent(2, 1, 0, 0, 120); ent(6, 1, 0, 0, 110);
    drive(1'b1, 2, 1'b0, "R6 oldest bubble entry");

    base(); ent(1, 0, 0, 0, 150); ent(3, 0, 0, 0, 130); ent(6, 0, 0, 0, 130);
    drive(1'b1, 3, 1'b0, "R7 soonest ready, tie to oldest");

    base(); ent(0, 0, 0, 0, 99); ent(1, 0, 0, 0, 50);
    drive(1'b1, 0, 1'b0, "R10 past ready clamped to now");

    base(); now = 16'd110; ent(0, 1, 0, 0, 20);
    drive(1'b1, 0, 1'b0, "R10 clamp creates gap");

    base(); dir_switch = 1'b1; ent(0, 1, 0, 0, 110);
    drive(1'b1, 0, 1'b1, "R9 direction switch extends deadline");

    base(); ent(0, 1, 0, 0, 110);
    drive(1'b1, 0, 1'b0, "R11 same entry no switch leaves gap");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule